// File: doc/BRIEF.md
# Offset-Frequency Oscillator Pair with Beat-Locked Sample Strobe

This block drives a heterodyne impedance or network measurement from one clock. It holds two phase accumulators. One runs at a base tuning word and sets the measurement frequency. The other runs at the base word plus an offset word, so it sits a small, exactly known step above the first. An external mixer that multiplies the two tones produces an intermediate frequency equal to that step. Because both accumulators share one clock, the step is exact.

A third accumulator runs at the offset word alone and follows the phase of the beat. Each time the beat crosses a quarter-cycle boundary, the block emits a one-clock sample strobe. A slow ADC that samples on this strobe takes four samples per beat period, locked to the beat. Alternate samples then form an in-phase and quadrature pair.

New words take effect only on a load pulse. A load resets all three accumulators together, so the relative phase after a load is known. If the base and offset sum does not fit in the tuning-word width, the load is refused and an error pulse is raised.

Top module: `offset_nco_pair`

## Requirements
- R1: While the reset input (`rst_n`, active low) is asserted, and in the first cycle after it is released, both phase outputs are 0 and `sample_stb` and `load_err` are low. All tuning words reset to 0.
- R2: Without a load, the measurement accumulator advances by the stored base word every clock, modulo 2^PW. `meas_phase` is its upper OUTW bits.
- R3: The second oscillator's word is the stored base word plus the stored offset word. It is stored in the same cycle as the base word. `lo_phase` is the upper OUTW bits of its accumulator. The full-width difference between the second and first accumulators always equals the offset accumulator.
- R4: `sample_stb` is high for exactly the one cycle that follows each clock edge in which the two most significant bits of the offset accumulator change. This gives four strobes per beat period when the offset word is below 2^(PW-2). With an offset word of 0 it never fires.
- R5: On an accepted load, all three accumulators become 0 at the same edge. Both phase outputs read 0 in the following cycle, and `sample_stb` is low in that cycle.
- R6: A load is refused when base plus offset does not fit in PW bits. In that case `load_err` is high for one cycle, the stored words are kept, and the accumulators keep advancing with the old words as if no load had occurred.
- R7: While `load` is low, changes on `base_word` and `offs_word` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all accumulators |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_word | input | PW | Base tuning word for the measurement frequency |
| offs_word | input | PW | Offset tuning word for the beat frequency |
| load | input | 1 | Samples both words and restarts the accumulators |
| meas_phase | output | OUTW | Phase of the measurement oscillator |
| lo_phase | output | OUTW | Phase of the offset oscillator |
| sample_stb | output | 1 | One-clock strobe at four times the beat frequency |
| load_err | output | 1 | One-clock pulse when a load is refused for overflow |

## Verification
The bench builds the block with PW=16 and OUTW=8. This makes a full beat period only a few tens of clocks long, so many strobe periods fit in a short run. A sum overflow can be reached with small hand-picked words. An offset word of 0x4000 puts a quadrant change on every edge, which is the limiting strobe case. Because OUTW=8, the truncated phase outputs also exercise the dropping of the low bits.

// File: rtl/offset_nco_pair.sv
module offset_nco_pair #(
  parameter int PW   = 32,
  parameter int OUTW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PW-1:0]   base_word,
  input  logic [PW-1:0]   offs_word,
  input  logic            load,
  output logic [OUTW-1:0] meas_phase,
  output logic [OUTW-1:0] lo_phase,
  output logic            sample_stb,
  output logic            load_err
);

  logic [PW-1:0] ftw_a, ftw_b, ftw_o;
  logic [PW-1:0] acc_a, acc_b, acc_o;
  logic [PW:0]   sum;
  logic          accept, ovf;
  logic [PW-1:0] acc_o_nx;

  assign sum      = {1'b0, base_word} + {1'b0, offs_word};
  assign ovf      = load & sum[PW];
  assign accept   = load & ~sum[PW];
  assign acc_o_nx = acc_o + ftw_o;

  assign meas_phase = acc_a[PW-1 -: OUTW];
  assign lo_phase   = acc_b[PW-1 -: OUTW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ftw_a <= '0;
      ftw_b <= '0;
      ftw_o <= '0;
    end else if (accept) begin
      ftw_a <= base_word;
      ftw_b <= sum[PW-1:0];
      ftw_o <= offs_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_a      <= '0;
      acc_b      <= '0;
      acc_o      <= '0;
      sample_stb <= 1'b0;
    end else if (accept) begin
      acc_a      <= '0;
      acc_b      <= '0;
      acc_o      <= '0;
      sample_stb <= 1'b0;
    end else begin
      acc_a      <= acc_a + ftw_a;
      acc_b      <= acc_b + ftw_b;
      acc_o      <= acc_o_nx;
      sample_stb <= acc_o_nx[PW-1 -: 2] != acc_o[PW-1 -: 2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_err <= 1'b0;
    else        load_err <= ovf;
  end

  // R3
  beat_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_b - acc_a) == acc_o);

  // R5
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (meas_phase == '0) && (lo_phase == '0) && !sample_stb);

  // R6
  err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |-> $stable(ftw_a) && $stable(ftw_b) && $stable(ftw_o));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(ftw_a) && $stable(ftw_o));

  // R6
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |-> !accept || $past(load));

endmodule

// File: tb/offset_nco_pair_test.sv
module offset_nco_pair_test;
  localparam int PW = 16;
  localparam int OUTW = 8;
  localparam time T_CLK = 10ns;

  typedef struct {
    logic [OUTW-1:0] mp;
    logic [OUTW-1:0] lp;
    logic            stb;
    logic            err;
    string           tag;
  } item_t;

  logic clk = 0, rst_n = 0, load = 0;
  logic [PW-1:0] base_word = '0, offs_word = '0;
  logic [OUTW-1:0] meas_phase, lo_phase;
  logic sample_stb, load_err;

  int checks = 0, failures = 0;
  bit done = 0;
  item_t q[$];

  logic [PW-1:0] ma = '0, mb = '0, mo = '0, fa = '0, fb = '0, fo = '0;

  offset_nco_pair #(.PW(PW), .OUTW(OUTW)) uut (
    .clk(clk), .rst_n(rst_n), .base_word(base_word), .offs_word(offs_word),
    .load(load), .meas_phase(meas_phase), .lo_phase(lo_phase),
    .sample_stb(sample_stb), .load_err(load_err));

  always #(T_CLK/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit ld, input logic [PW-1:0] b,
                     input logic [PW-1:0] o, input string tag);
    logic [PW:0] s;
    logic [1:0] qo;
    item_t it;
    @(negedge clk);
    load = ld; base_word = b; offs_word = o;
    s = {1'b0, b} + {1'b0, o};
    it.err = ld && s[PW];
    if (ld && !s[PW]) begin
      fa = b; fb = s[PW-1:0]; fo = o;
      ma = '0; mb = '0; mo = '0;
      it.stb = 1'b0;
    end else begin
      qo = mo[PW-1 -: 2];
      ma = ma + fa; mb = mb + fb; mo = mo + fo;
      it.stb = mo[PW-1 -: 2] != qo;
    end
    it.mp = ma[PW-1 -: OUTW];
    it.lp = mb[PW-1 -: OUTW];
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, base_word, offs_word, tag);
  endtask

  initial begin : monitor
    item_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(meas_phase == e.mp, {e.tag, " R2"}, "meas_phase", meas_phase, e.mp);
        chk(lo_phase == e.lp, {e.tag, " R3"}, "lo_phase", lo_phase, e.lp);
        chk(sample_stb == e.stb, {e.tag, " R4"}, "sample_stb", sample_stb, e.stb);
        chk(load_err == e.err, {e.tag, " R6"}, "load_err", load_err, e.err);
      end
    end
  end

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(T_CLK * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin : driver
    int stb_cnt;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(meas_phase == 0 && lo_phase == 0, "R1", "phases in reset", {meas_phase, lo_phase}, 0);
    chk(!sample_stb && !load_err, "R1", "flags in reset", {sample_stb, load_err}, 0);
    rst_n = 1;
    @(posedge clk); #1;
    chk(meas_phase == 0 && lo_phase == 0 && !sample_stb, "R1", "first cycle after reset", {meas_phase, lo_phase}, 0);

    cyc(1'b1, 16'h0300, 16'h1000, "R5 load");
    @(posedge clk); #1;
    chk(meas_phase == 0 && lo_phase == 0, "R5", "phases after load", {meas_phase, lo_phase}, 0);
    run(40, "base run");

    // R7: words change without load
    for (int i = 0; i < 10; i++) cyc(1'b0, 16'h7777 + 16'(i), 16'h2345, "R7 idle");

    cyc(1'b1, 16'h2A00, 16'h0800, "R5 reload");
    run(40, "slow beat");

    // R6: overflowing load keeps old words
    cyc(1'b1, 16'hF000, 16'h2000, "R6 overflow");
    run(20, "R6 after overflow");

    // R4: zero offset never strobes
    cyc(1'b1, 16'h0100, 16'h0000, "R4 zero offset");
    stb_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      cyc(1'b0, 16'h0100, 16'h0000, "R4 zero offset run");
      @(posedge clk); #1;
      if (sample_stb) stb_cnt++;
    end
    chk(stb_cnt == 0, "R4", "strobes at zero offset", stb_cnt, 0);

    // R4: quadrant change every edge
    cyc(1'b1, 16'h0040, 16'h4000, "R4 fast beat");
    run(12, "R4 fast beat run");

    // R4: four strobes per beat period of 16 clocks
    cyc(1'b1, 16'h0500, 16'h1000, "R4 count");
    stb_cnt = 0;
    for (int i = 0; i < 32; i++) begin
      cyc(1'b0, 16'h0500, 16'h1000, "R4 count run");
      @(posedge clk); #1;
      if (sample_stb) stb_cnt++;
    end
    chk(stb_cnt == 8, "R4", "strobes in two beat periods", stb_cnt, 8);

    @(negedge clk);
    @(negedge clk);
    finish_up();
  end
endmodule